// File: doc/BRIEF.md
# Circular FIFO with Independent Occupancy Counter

A single-clock first-in first-out queue built on a circular storage array of `DEPTH` words. Two instances of one address generator supply the write and read slots. Each generator starts at slot 0 and steps by one on each enabled cycle. After the last slot it returns to 0.

A separate occupancy counter tracks how many words are held. It is kept apart from the two pointers. Embedded assertions check that it always agrees with the wrapped distance between the pointers.

Writes are never refused. A write into a full queue replaces the oldest word. The read slot moves forward in that same cycle, so the queue keeps the newest `DEPTH` words. Read data is registered: a read taken on one clock edge shows its word on `rd_data` after that edge. A read request while the queue is empty is ignored.

Top module: `ring_fifo`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `count` is 0, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: Words come out on `rd_data` in the order they were written.
- R3: On a clock edge with `wr_en` high, `rd_en` low and the queue not full, `count` rises by 1. With `rd_en` high, `wr_en` low and the queue not empty, it falls by 1. With both high and the queue not empty, it is unchanged. `count` never exceeds `DEPTH`.
- R4: `full` is 1 exactly when `count` equals `DEPTH`. `empty` is 1 exactly when `count` is 0.
- R5: `rd_data` changes only on an edge where a read is accepted. It then holds the word at the head of the queue as it stood before that edge, and keeps that value until the next accepted read.
- R6: A write while full, with no read, discards the oldest word and stores the new one. `count` stays at `DEPTH` and `rd_data` is unchanged.
- R7: A read and a write on the same edge while full return the oldest word on `rd_data`, store the new word, and leave `count` at `DEPTH`.
- R8: A read request while empty has no effect: `count`, `empty` and `rd_data` keep their values.
- R9: Each address generator steps from slot `DEPTH-1` back to 0. The occupancy count always equals the wrapped pointer difference, or equals `DEPTH` when that difference is 0 and the queue is full.
- R10: The read slot does not move on an edge with no read request while the queue is not full. An accepted read always moves it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` this cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Take the head word this cycle |
| rd_data | output | WIDTH | Registered word from the last accepted read |
| full | output | 1 | Queue holds `DEPTH` words |
| empty | output | 1 | Queue holds no words |
| count | output | $clog2(DEPTH+1) | Number of words held |

## Verification
Because the count is held apart from the pointers, a counter that drifts from the pointer gap shows on `full` and `empty` at the next edge. After that it shows as wrong, repeated or skipped words on `rd_data`, one cycle after the read that exposes it. A read slot that moves when it should not, or fails to wrap, corrupts the sequence on the very next accepted read. The bench therefore compares every output after every edge against a queue model that includes the overwrite behaviour. It also runs long enough for both pointers to wrap several times.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_t;

endpackage

// File: rtl/ring_fifo_ptr.sv
module ring_fifo_ptr #(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_d, addr_q;

  always_comb begin
    addr_d = addr_q;
    if (adv) begin
      if (addr_q == LAST) addr_d = '0;
      else                addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> addr == (($past(addr) == LAST) ? '0 : $past(addr) + 1'b1)); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(addr)); // R10
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    addr <= LAST); // R9

endmodule

// File: rtl/ring_fifo_occ.sv
module ring_fifo_occ
  import ring_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  fifo_op_t      op;
  logic [CW-1:0] cnt_d, cnt_q;

  assign op = fifo_op_t'({push, pop});

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      OP_PUSH: if (cnt_q != CAP) cnt_d = cnt_q + 1'b1;
      OP_POP:  cnt_d = cnt_q - 1'b1;
      OP_BOTH: cnt_d = cnt_q;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign full  = (cnt_q == CAP);
  assign empty = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1
              || count == $past(count) - 1'b1)); // R3
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R4

endmodule

// File: rtl/ring_fifo_store.sv
module ring_fifo_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_d, rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R5

endmodule

// File: rtl/ring_fifo.sv
module ring_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           rd_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [AW-1:0] waddr, raddr;
  logic          pop, radv;
  logic [CW-1:0] gap;

  // A read is accepted only when data is held. A write into a full queue
  // drags the read slot forward so the oldest word is dropped.
  assign pop  = rd_en & ~empty;
  assign radv = pop | (wr_en & full);

  ring_fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_en), .addr(waddr)
  );

  ring_fifo_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk(clk), .rst_n(rst_n), .adv(radv), .addr(raddr)
  );

  ring_fifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .pop(pop),
    .count(count), .full(full), .empty(empty)
  );

  ring_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(waddr), .wdata(wr_data),
    .re(pop), .raddr(raddr), .rdata(rd_data)
  );

  // Wrapped distance between pointers, used only by the checks below.
  always_comb begin
    if (waddr >= raddr) gap = CW'(waddr) - CW'(raddr);
    else                gap = CW'(waddr) + CAP - CW'(raddr);
  end

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (count == gap) || (count == CAP && gap == '0)); // R9
  AST_RADDR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !empty) |=> raddr != $past(raddr) || DEPTH == 1); // R10
  AST_RADDR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !full) |=> $stable(raddr)); // R10
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && empty) |=> (empty && $stable(rd_data))); // R8
  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> full); // R6

endmodule

// File: tb/ring_fifo_test.sv
module ring_fifo_test;

  localparam int DEPTH = 4;
  localparam int WIDTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en, rd_en;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] rd_data;
  logic             full, empty;
  logic [CW-1:0]    count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [WIDTH-1:0] q [$];
  logic [WIDTH-1:0] exp_rd;

  always #2.5 clk = ~clk;

  ring_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
    .count(count)
  );

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [WIDTH-1:0] d;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0, 8'h11}, '{1'b1, 1'b0, 8'h22}, '{1'b0, 1'b1, 8'h00},
    '{1'b1, 1'b1, 8'h33}, '{1'b1, 1'b0, 8'h44}, '{1'b1, 1'b0, 8'h55},
    '{1'b1, 1'b0, 8'h66}, '{1'b1, 1'b0, 8'h77}, '{1'b1, 1'b1, 8'h88},
    '{1'b0, 1'b0, 8'h00}, '{1'b0, 1'b1, 8'h00}, '{1'b0, 1'b1, 8'h00},
    '{1'b1, 1'b1, 8'h99}, '{1'b0, 1'b1, 8'h00}, '{1'b0, 1'b1, 8'h00},
    '{1'b0, 1'b1, 8'h00}, '{1'b0, 1'b1, 8'h00}, '{1'b1, 1'b0, 8'hAA},
    '{1'b0, 1'b1, 8'h00}, '{1'b0, 1'b0, 8'h00}
  };

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "count", int'(count), q.size());
    check(tag, "full", int'(full), int'(q.size() == DEPTH));
    check(tag, "empty", int'(empty), int'(q.size() == 0));
    check(tag, "rd_data", int'(rd_data), int'(exp_rd));
  endtask

  // Drive one cycle at the falling edge, update the model at the rising
  // edge, compare at the next falling edge.
  task automatic step(input logic w, input logic r, input logic [WIDTH-1:0] d,
                      input string tag);
    bit pop;
    wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    pop = r && (q.size() > 0);
    if (pop) begin
      exp_rd = q[0];
      void'(q.pop_front());
    end
    if (w) begin
      if (q.size() == DEPTH) void'(q.pop_front());
      q.push_back(d);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    q.delete(); exp_rd = '0;
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
  endtask

  initial begin
    do_reset();

    // Vector table: mixed pushes, pops, overwrite and both-while-full
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].rd, VEC[i].d, "R2/R3/R5");
    end

    // R8: read on empty is ignored
    while (q.size() > 0) step(1'b0, 1'b1, '0, "R2");
    step(1'b0, 1'b1, '0, "R8");
    step(1'b0, 1'b1, '0, "R8");

    // R10: writes without reads leave head in place
    step(1'b1, 1'b0, 8'hC1, "R10");
    step(1'b1, 1'b0, 8'hC2, "R10");
    step(1'b0, 1'b0, '0, "R10");
    step(1'b0, 1'b1, '0, "R10");

    // R4/R6: fill, then overwrite twice
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, WIDTH'(8'hD0 + i), "R4");
    step(1'b1, 1'b0, 8'hE1, "R6");
    step(1'b1, 1'b0, 8'hE2, "R6");
    // R7: read+write while full
    step(1'b1, 1'b1, 8'hE3, "R7");
    step(1'b1, 1'b1, 8'hE4, "R7");
    while (q.size() > 0) step(1'b0, 1'b1, '0, "R6");

    // R9: long run so both pointers wrap many times
    for (int i = 0; i < 60; i++) begin
      step(1'b1, (i % 3) != 0, WIDTH'(i * 7 + 1), "R9");
    end
    while (q.size() > 0) step(1'b0, 1'b1, '0, "R9");

    // R1: reset in the middle of traffic
    step(1'b1, 1'b0, 8'h5A, "R3");
    step(1'b1, 1'b0, 8'h5B, "R3");
    step(1'b0, 1'b1, '0, "R5");
    do_reset();
    step(1'b1, 1'b0, 8'h6C, "R3");
    step(1'b0, 1'b1, '0, "R2");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule